// File: doc/BRIEF.md
# Edge-Pair Period Meter

This block measures the period of an external digital signal in units of the system clock. The signal is first passed through a synchroniser. Each rising edge is then stamped with the value of a free-running counter. Edges are taken in pairs. The first edge of a pair records a start stamp and arms the pair. The second edge closes the pair and produces the difference between the two stamps.

A pair is only valid while the counter has not wrapped in between. Any counter wrap disarms a pending pair. If the closing edge finds the pair disarmed, the counter is restarted from zero, so the next pair gets a full counting range. The wraps also drive a slow report strobe, which a downstream display can use to refresh itself. Converting the period to a frequency is left to the consumer.

Top module: `edge_period_meter`

## Requirements
- R1: The timebase counter is CNT_W bits wide. It steps by one on every clock and rolls from all-ones back to zero. Such a roll-over is a wrap. The only exception is the restart described in R6, which loads zero instead.
- R2: The input is sampled through SYNC_STAGES flops, and only a low-to-high transition registers as an edge. The edge's stamp is the counter value at detection minus SYNC_STAGES, taken modulo 2^CNT_W.
- R3: Edges alternate between two roles, opener and closer, starting with opener after reset. An opener stores its stamp and arms the pair. A closer that finds the pair armed, with a stamp strictly greater than the stored one, raises `period_valid_o` one clock after detection, with `period_o` equal to the stamp difference.
- R4: A closer that finds the pair armed but with a stamp not greater than the stored one produces no output, and does not restart the counter.
- R5: A wrap disarms a pending pair. An opener detected in the same clock as a wrap is left disarmed.
- R6: A closer that finds the pair disarmed produces no output and loads zero into the counter. A cycle in which this happens does not count as a wrap.
- R7: After every closer, armed or not, the next edge acts as an opener.
- R8: `period_valid_o` lasts exactly one clock. `period_o` keeps its last accepted value until the next accepted measurement.
- R9: Every REPORT_WRAPS-th wrap raises `report_o` for one clock, starting one clock after that wrap. The wrap count then restarts.
- R10: While `rst_n` is low, `period_o`, `period_valid_o` and `report_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also the timebase of the measurement |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | 1 | Asynchronous signal whose period is measured |
| period_o | output | CNT_W | Last accepted period in clock cycles |
| period_valid_o | output | 1 | One-clock strobe marking a new accepted period |
| report_o | output | 1 | One-clock strobe after every REPORT_WRAPS wraps |

## Verification
The bench drives a fast two-cycle square wave across several wraps. This hits the rare path where a disarmed closer restarts the counter and the next opener stamps a wrapped-around value. In that case a correct design must drop the following pair under R4; a design that skips the restart, or does not compare the stamps, emits a huge bogus period. Slow square waves longer than the wrap interval check that no pair that spans a wrap is ever accepted. A short regular train with a known period catches an off-by-one in stamp compensation. Random pulse widths, together with a long idle stretch, check the report cadence; a design that counts the restart cycle as a wrap drifts out of step with the reference.

// File: rtl/epm_pkg.sv
package epm_pkg;

  typedef enum logic {
    ROLE_OPEN  = 1'b0,
    ROLE_CLOSE = 1'b1
  } edge_role_t;

  // Stamp compensation: counter value minus pipeline lag, modulo 2^w.
  function automatic logic [31:0] back_stamp(input logic [31:0] cnt, input int lag, input int w);
    logic [31:0] mask;
    mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (cnt - 32'(lag)) & mask;
  endfunction

  // A pair is usable only when the closing stamp is strictly later.
  function automatic logic pair_ordered(input logic [31:0] t_open, input logic [31:0] t_close);
    return t_close > t_open;
  endfunction

endpackage

// File: rtl/epm_sync_edge.sv
module epm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise_o
);
  // pipe[STAGES-1] is the synchronised level, pipe[STAGES] its previous value
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], din};
  end

  assign rise_o = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/epm_free_counter.sv
module epm_free_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  output logic [W-1:0] value_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] TOP = '1;

  assign wrap_o = (value_o == TOP) && !clear_i;

  always_ff @(posedge clk) begin
    if (!rst_n)       value_o <= '0;
    else if (clear_i) value_o <= '0;
    else              value_o <= value_o + 1'b1;
  end
endmodule

// File: rtl/epm_capture.sv
module epm_capture
  import epm_pkg::*;
#(
  parameter int W   = 16,
  parameter int LAG = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rise_i,
  input  logic         wrap_i,
  input  logic [W-1:0] cnt_i,
  output logic         clear_o,
  output logic [W-1:0] period_o,
  output logic         valid_o,
  output logic         armed_o,
  output edge_role_t   role_o
);
  logic [W-1:0] stamp;
  logic [W-1:0] t_open;
  logic         open_hit;
  logic         close_hit;
  logic         accept;

  assign stamp     = W'(back_stamp(32'(cnt_i), LAG, W));
  assign open_hit  = rise_i && (role_o == ROLE_OPEN);
  assign close_hit = rise_i && (role_o == ROLE_CLOSE);
  assign accept    = close_hit && armed_o && pair_ordered(32'(t_open), 32'(stamp));
  assign clear_o   = close_hit && !armed_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      role_o   <= ROLE_OPEN;
      armed_o  <= 1'b0;
      t_open   <= '0;
      period_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= accept;
      if (accept) period_o <= stamp - t_open;
      if (rise_i) role_o <= (role_o == ROLE_OPEN) ? ROLE_CLOSE : ROLE_OPEN;
      if (open_hit) begin
        t_open  <= stamp;
        armed_o <= !wrap_i;
      end else if (close_hit || wrap_i) begin
        armed_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/epm_wrap_pacer.sv
module epm_wrap_pacer #(
  parameter int COUNT = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_i,
  output logic report_o
);
  localparam int CW = (COUNT > 1) ? $clog2(COUNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(COUNT - 1);

  logic [CW-1:0] wraps;
  logic          at_last;

  assign at_last = (wraps == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wraps    <= '0;
      report_o <= 1'b0;
    end else begin
      report_o <= wrap_i && at_last;
      if (wrap_i) wraps <= at_last ? '0 : wraps + 1'b1;
    end
  end
endmodule

// File: rtl/edge_period_meter.sv
module edge_period_meter
  import epm_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int REPORT_WRAPS = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_in,
  output logic [CNT_W-1:0] period_o,
  output logic             period_valid_o,
  output logic             report_o
);
  // named internal events, observed by the bound checker
  logic             rise_evt;
  logic             wrap_evt;
  logic             clear_evt;
  logic             armed;
  edge_role_t       role;
  logic [CNT_W-1:0] cnt;

  epm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (sig_in),
    .rise_o (rise_evt)
  );

  epm_free_counter #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (clear_evt),
    .value_o (cnt),
    .wrap_o  (wrap_evt)
  );

  epm_capture #(.W(CNT_W), .LAG(SYNC_STAGES)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_i   (rise_evt),
    .wrap_i   (wrap_evt),
    .cnt_i    (cnt),
    .clear_o  (clear_evt),
    .period_o (period_o),
    .valid_o  (period_valid_o),
    .armed_o  (armed),
    .role_o   (role)
  );

  epm_wrap_pacer #(.COUNT(REPORT_WRAPS)) u_pace (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrap_i   (wrap_evt),
    .report_o (report_o)
  );
endmodule

// File: rtl/epm_checker.sv
module epm_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rise_evt,
  input logic         wrap_evt,
  input logic         clear_evt,
  input logic         armed,
  input logic         role_close,
  input logic [W-1:0] cnt,
  input logic [W-1:0] period,
  input logic         valid,
  input logic         report
);
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_evt |=> (W'(cnt - $past(cnt)) == W'(1)));

  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> (cnt == '0));

  p_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !(rise_evt && !role_close)) |=> !armed);

  p_back_to_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && role_close) |=> !role_close);

  p_positive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (period != '0));

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(period));

  p_report_after_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    report |-> $past(wrap_evt));
endmodule

bind edge_period_meter epm_checker #(.W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rise_evt   (rise_evt),
  .wrap_evt   (wrap_evt),
  .clear_evt  (clear_evt),
  .armed      (armed),
  .role_close (role == epm_pkg::ROLE_CLOSE),
  .cnt        (cnt),
  .period     (period_o),
  .valid      (period_valid_o),
  .report     (report_o)
);

// File: tb/edge_period_meter_tb.sv
module edge_period_meter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW    = 10;
  localparam int LAG   = 2;
  localparam int NREP  = 60;
  localparam int MASK  = (1 << CW) - 1;
  localparam int WD_CYCLES = 190000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sig = 1'b0;
  logic [CW-1:0] p_period;
  logic          p_valid;
  logic          p_report;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  bit run_chk = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_period_meter #(.CNT_W(CW), .SYNC_STAGES(LAG), .REPORT_WRAPS(NREP)) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .sig_in         (sig),
    .period_o       (p_period),
    .period_valid_o (p_valid),
    .report_o       (p_report)
  );

  // ---- reference model, written from the requirements ----
  function automatic int unsigned ref_stamp(int unsigned c);
    return (c + MASK + 1 - LAG) & MASK;   // R2
  endfunction

  int unsigned m_cnt, m_t1, m_period;
  int          m_wraps;
  bit          m_s1, m_s2, m_s3, m_closer, m_armed, m_valid, m_report;
  int n_clr = 0, n_r4 = 0, n_rep_dut = 0, n37 = 0;

  always @(posedge clk) begin
    bit r, w, c, op, cl;
    int unsigned st;
    if (!rst_n) begin
      m_cnt <= 0; m_t1 <= 0; m_period <= 0; m_wraps <= 0;
      m_s1 <= 0; m_s2 <= 0; m_s3 <= 0;
      m_closer <= 0; m_armed <= 0; m_valid <= 0; m_report <= 0;
    end else begin
      r  = m_s2 && !m_s3;
      st = ref_stamp(m_cnt);
      op = r && !m_closer;
      cl = r && m_closer;
      c  = cl && !m_armed;                       // R6
      w  = (m_cnt == MASK) && !c;                // R1
      m_valid  <= 1'b0;
      m_report <= 1'b0;
      if (cl && m_armed) begin
        if (st > m_t1) begin m_valid <= 1'b1; m_period <= st - m_t1; end   // R3
        else n_r4++;                                                        // R4
      end
      if (c) begin m_cnt <= 0; n_clr++; end else m_cnt <= (m_cnt + 1) & MASK;
      if (op) begin m_t1 <= st; m_armed <= !w; end                           // R5
      else if (cl || w) m_armed <= 1'b0;
      if (r) m_closer <= !m_closer;                                          // R7
      if (w) begin
        if (m_wraps == NREP - 1) begin m_wraps <= 0; m_report <= 1'b1; end   // R9
        else m_wraps <= m_wraps + 1;
      end
      m_s1 <= sig; m_s2 <= m_s1; m_s3 <= m_s2;
    end
  end

  // ---- comparison away from the active edge ----
  always @(negedge clk) begin
    if (rst_n && run_chk && !finished) begin
      if (p_valid || m_valid) begin
        tests++;
        if (p_valid !== m_valid || (m_valid && p_period !== CW'(m_period))) begin
          fails++;
          $display("FAIL R3/R7: valid=%0b period=%0d expected valid=%0b period=%0d",
                   p_valid, p_period, m_valid, m_period);
        end
      end else if (p_period !== CW'(m_period)) begin
        tests++; fails++;
        $display("FAIL R8: held period=%0d expected %0d", p_period, m_period);
      end
      if (p_report || m_report) begin
        tests++;
        if (p_report !== m_report) begin
          fails++;
          $display("FAIL R9: report=%0b expected %0b", p_report, m_report);
        end
      end
      if (p_report) n_rep_dut++;
      if (p_valid && p_period == CW'(37)) n37++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic square(input int hi, input int lo, input int reps);
    for (int i = 0; i < reps; i++) begin
      @(negedge clk) sig = 1'b1;
      repeat (hi - 1) @(negedge clk);
      @(negedge clk) sig = 1'b0;
      repeat (lo - 1) @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    // R10: outputs idle under reset
    check(p_period == '0, "R10 period", int'(p_period), 0);
    check(p_valid == 1'b0, "R10 valid", int'(p_valid), 0);
    check(p_report == 1'b0, "R10 report", int'(p_report), 0);
    @(negedge clk) rst_n = 1'b1;
    run_chk = 1;

    // R2, R3: regular train with a 37-cycle period
    square(20, 17, 40);
    check(n37 > 0, "R2/R3 period 37 seen", n37, 1);

    // R4, R6: two-cycle toggling across several wraps
    square(1, 1, 3000);
    check(n_r4 > 0, "R4 misordered pair dropped", n_r4, 1);

    // random pulse widths
    for (int k = 0; k < 300; k++) square($urandom_range(1, 200), $urandom_range(1, 200), 1);

    // R5, R6: every pair spans a wrap and must be rejected
    square(600, 600, 10);
    check(n_clr > 0, "R5/R6 spanning pairs restarted", n_clr, 1);

    // R1, R9: idle stretch so the wrap pacing is visible
    sig = 1'b0;
    repeat (20000) @(negedge clk);
    check(n_rep_dut > 0, "R1/R9 report strobes", n_rep_dut, 1);

    repeat (5) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end
endmodule